// File: doc/BRIEF.md
# Preloaded PHY Error Trigger Counters

This block holds two 24-bit event counters that watch a per-cycle stream of receive-error strobes. Each strobe carries a small type code. Each counter advances only on the codes its select mask enables. By convention, code 1 is an OFDM timing error and code 2 is a CCK timing error. No comparator checks a threshold. Instead, software programs a trigger count, and a restart preloads each counter with a base value that lies that many steps below the point where the two top bits turn on. When either counter crosses into that region, the shared interrupt output goes high.

Software writes counters, masks and triggers through a one-cycle register write port. The counter values are available at all times on output ports and are never cleared by being observed. The block also presents, for each counter, the number of errors counted since the last load, and clamps that figure when the counter sits below its base. Two auxiliary filtered-frame tallies run beside the error counters. The interrupt service strobe wipes both tallies, whichever source raised the interrupt.

Each error counter carries a four-state machine that tracks its value and mask:
- CH_OFF: mask empty, not fired.
- CH_ARMED: counting, not fired.
- CH_FIRED: top two bits set, below all ones.
- CH_PEGGED: all ones, no further increments.

After every counter update, the next state is chosen from the new value and mask:
- To CH_PEGGED when the value becomes all ones.
- To CH_FIRED when the top two bits are set.
- To CH_OFF when the mask is zero.
- To CH_ARMED otherwise.

Loads can move a channel between any two states.

Top module: `phyerr_trig_ctr`

## Requirements
- R1: After reset both counters, masks, triggers and auxiliary tallies are zero and `irq` is low.
- R2: `irq` is high exactly when either counter has its two most significant bits both set, and it stays high until that counter is written or reloaded.
- R3: The base of a counter is 0xC00000 minus its trigger, or 0 when the trigger is 0xC00000 or more; a `restart` pulse loads both counters with their bases.
- R4: A counter advances by one in a cycle where `evt_valid` is high and bit `evt_code` of its mask is set; an empty mask stops counting, and one strobe may advance both counters.
- R5: A counter that reaches 0xFFFFFF holds that value on further events and never wraps.
- R6: `elapsed_a`/`elapsed_b` equal the counter minus its base, or 0xC00000 when the counter is below the base.
- R7: Write addresses: 0 and 1 load counters A and B, 2 and 3 load masks A and B (low 8 data bits), 4 and 5 load triggers A and B; any other address changes nothing.
- R8: Each auxiliary tally counts its `filt_evt` bit and saturates at all ones; `svc_clr` zeroes both and wins over a strobe in the same cycle.
- R9: A write to a counter wins over an event strobe and over `restart` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 24 | Register write data |
| restart | input | 1 | Reload both counters with their bases |
| evt_valid | input | 1 | Error strobe this cycle |
| evt_code | input | 3 | Error type of the strobe |
| filt_evt | input | 2 | Filtered-frame strobes for tally A (bit 0) and B (bit 1) |
| svc_clr | input | 1 | Interrupt service: clear both tallies |
| cnt_a | output | 24 | Counter A value |
| cnt_b | output | 24 | Counter B value |
| elapsed_a | output | 24 | Errors on counter A since its load |
| elapsed_b | output | 24 | Errors on counter B since its load |
| aux_a | output | 16 | Filtered-frame tally A |
| aux_b | output | 16 | Filtered-frame tally B |
| irq | output | 1 | Trigger interrupt |

## Verification
Two functions can land on the same clock edge.

The first collision is a software load of a counter against an error strobe. It is provoked by holding a counter write and a matching strobe high in one cycle. The result is judged by whether the counter shows the written value, with no increment on top. The same approach is used for a counter write against `restart`.

The second collision is the service clear against a filtered-frame strobe. It is provoked by pulsing both together after the tallies have been raised. The result is judged by whether both tallies read zero on the next cycle.

// File: rtl/pet_pkg.sv
package pet_pkg;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_ARMED,
        CH_FIRED,
        CH_PEGGED
    } chan_state_e;

    localparam logic [2:0] ADDR_CNT0  = 3'd0;
    localparam logic [2:0] ADDR_MASK0 = 3'd2;
    localparam logic [2:0] ADDR_TRIG0 = 3'd4;

endpackage

// File: rtl/pet_chan.sv
module pet_chan
    import pet_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_cnt,
    input  logic              ld_mask,
    input  logic              ld_trig,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              restart,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  elapsed_o,
    output logic              fired_o
);

    localparam int MASK_W = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {2'b11, {(CNT_W-2){1'b0}}};

    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic [CNT_W-1:0]  trig_q;
    logic [CNT_W-1:0]  base_w;
    chan_state_e       state_q, state_d;
    logic              can_inc;
    logic              hit;

    // base: distance below the fire point equals the trigger
    always_comb begin
        if (trig_q >= CNT_MAX) base_w = '0;
        else                   base_w = CNT_MAX - trig_q;
    end

    assign hit    = evt_valid && mask_q[evt_code];
    assign mask_d = ld_mask ? wdata[MASK_W-1:0] : mask_q;

    // priority: software load, then restart, then increment
    always_comb begin
        if (ld_cnt)                cnt_d = wdata;
        else if (restart)          cnt_d = base_w;
        else if (hit && can_inc)   cnt_d = cnt_q + 1'b1;
        else                       cnt_d = cnt_q;
    end

    always_comb begin
        if (&cnt_d)                     state_d = CH_PEGGED;
        else if (&cnt_d[CNT_W-1 -: 2])  state_d = CH_FIRED;
        else if (mask_d == '0)          state_d = CH_OFF;
        else                            state_d = CH_ARMED;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            CH_OFF:    begin fired_o = 1'b0; can_inc = 1'b1; end
            CH_ARMED:  begin fired_o = 1'b0; can_inc = 1'b1; end
            CH_FIRED:  begin fired_o = 1'b1; can_inc = 1'b1; end
            CH_PEGGED: begin fired_o = 1'b1; can_inc = 1'b0; end
            default:   begin fired_o = 1'b0; can_inc = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mask_q <= '0;
            trig_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            mask_q <= mask_d;
            if (ld_trig) trig_q <= wdata;
        end
    end

    assign cnt_o     = cnt_q;
    assign elapsed_o = (cnt_q >= base_w) ? (cnt_q - base_w) : CNT_MAX;

endmodule

// File: rtl/pet_aux.sv
module pet_aux #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)              q <= '0;
        else if (clr)            q <= '0;
        else if (inc && !(&q))   q <= q + 1'b1;
    end

endmodule

// File: rtl/phyerr_trig_ctr.sv
module phyerr_trig_ctr
    import pet_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int CODE_W = 3,
    parameter int AUX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              restart,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic [1:0]        filt_evt,
    input  logic              svc_clr,
    output logic [CNT_W-1:0]  cnt_a,
    output logic [CNT_W-1:0]  cnt_b,
    output logic [CNT_W-1:0]  elapsed_a,
    output logic [CNT_W-1:0]  elapsed_b,
    output logic [AUX_W-1:0]  aux_a,
    output logic [AUX_W-1:0]  aux_b,
    output logic              irq
);

    localparam int NCH = 2;

    logic [CNT_W-1:0] cnt_w     [NCH];
    logic [CNT_W-1:0] elapsed_w [NCH];
    logic [AUX_W-1:0] aux_w     [NCH];
    logic [NCH-1:0]   fired_w;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic ld_cnt, ld_mask, ld_trig;
        assign ld_cnt  = wr_en && (wr_addr == ADDR_CNT0  + 3'(ch));
        assign ld_mask = wr_en && (wr_addr == ADDR_MASK0 + 3'(ch));
        assign ld_trig = wr_en && (wr_addr == ADDR_TRIG0 + 3'(ch));

        pet_chan #(.CNT_W(CNT_W), .CODE_W(CODE_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_cnt    (ld_cnt),
            .ld_mask   (ld_mask),
            .ld_trig   (ld_trig),
            .wdata     (wr_data),
            .restart   (restart),
            .evt_valid (evt_valid),
            .evt_code  (evt_code),
            .cnt_o     (cnt_w[ch]),
            .elapsed_o (elapsed_w[ch]),
            .fired_o   (fired_w[ch])
        );

        pet_aux #(.W(AUX_W)) aux_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (filt_evt[ch]),
            .clr   (svc_clr),
            .q     (aux_w[ch])
        );
    end

    assign cnt_a     = cnt_w[0];
    assign cnt_b     = cnt_w[1];
    assign elapsed_a = elapsed_w[0];
    assign elapsed_b = elapsed_w[1];
    assign aux_a     = aux_w[0];
    assign aux_b     = aux_w[1];
    assign irq       = |fired_w;

endmodule

// File: rtl/pet_chk.sv
module pet_chk #(
    parameter int CNT_W  = 24,
    parameter int CODE_W = 3,
    parameter int AUX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              restart,
    input logic              svc_clr,
    input logic [CNT_W-1:0]  cnt_a,
    input logic [CNT_W-1:0]  cnt_b,
    input logic [CNT_W-1:0]  elapsed_a,
    input logic [CNT_W-1:0]  elapsed_b,
    input logic [AUX_W-1:0]  aux_a,
    input logic [AUX_W-1:0]  aux_b,
    input logic              irq
);

    a_r2_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((&cnt_a[CNT_W-1 -: 2]) || (&cnt_b[CNT_W-1 -: 2])));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !restart) |=> (CNT_W'(cnt_a - $past(cnt_a)) <= CNT_W'(1)));

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_a) && !wr_en && !restart) |=> (&cnt_a));

    a_r3_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !wr_en) |=> (elapsed_a == '0 && elapsed_b == '0));

    a_r8_aux_clear: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clr |=> (aux_a == '0 && aux_b == '0));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (cnt_a == $past(wr_data)));

endmodule

bind phyerr_trig_ctr pet_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W), .AUX_W(AUX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .restart   (restart),
    .svc_clr   (svc_clr),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .elapsed_a (elapsed_a),
    .elapsed_b (elapsed_b),
    .aux_a     (aux_a),
    .aux_b     (aux_b),
    .irq       (irq)
);

// File: tb/phyerr_trig_ctr_tb_top.sv
module phyerr_trig_ctr_tb_top;

    localparam int CW = 24;
    localparam logic [CW-1:0] CMAX = 24'hC00000;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [CW-1:0] wr_data = 0;
    logic restart = 0, evt_valid = 0, svc_clr = 0;
    logic [2:0] evt_code = 0;
    logic [1:0] filt_evt = 0;
    logic [CW-1:0] cnt_a, cnt_b, elapsed_a, elapsed_b;
    logic [15:0] aux_a, aux_b;
    logic irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phyerr_trig_ctr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .restart(restart), .evt_valid(evt_valid),
        .evt_code(evt_code), .filt_evt(filt_evt), .svc_clr(svc_clr),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .elapsed_a(elapsed_a),
        .elapsed_b(elapsed_b), .aux_a(aux_a), .aux_b(aux_b), .irq(irq)
    );

    function automatic logic [CW-1:0] exp_base(input logic [CW-1:0] t);
        return (t >= CMAX) ? '0 : CMAX - t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_restart();
        restart = 1; @(negedge clk); restart = 0;
    endtask

    task automatic events(input logic [2:0] code, input int n);
        for (int i = 0; i < n; i++) begin
            evt_valid = 1; evt_code = code; @(negedge clk);
        end
        evt_valid = 0;
    endtask

    task automatic t_reset();
        check("R1 cnt_a", cnt_a, 0);
        check("R1 cnt_b", cnt_b, 0);
        check("R1 irq", irq, 0);
        check("R1 aux", {aux_a, aux_b}, 0);
        check("R6 elapsed below base", elapsed_a, CMAX);
    endtask

    task automatic t_setup();
        wr(3'd2, 24'h02); wr(3'd3, 24'h04);
        wr(3'd4, 24'd5);  wr(3'd5, 24'd3);
        pulse_restart();
        check("R3 base a", cnt_a, exp_base(24'd5));
        check("R3 base b", cnt_b, exp_base(24'd3));
        check("R6 elapsed zero", elapsed_a, 0);
        check("R2 irq low", irq, 0);
    endtask

    task automatic t_fire();
        events(3'd1, 4);
        check("R4 count a", cnt_a, 24'hBFFFFF);
        check("R4 mask b", cnt_b, exp_base(24'd3));
        check("R2 not yet", irq, 0);
        events(3'd1, 1);
        check("R2 fires", irq, 1);
        check("R6 elapsed five", elapsed_a, 5);
        repeat (3) @(negedge clk);
        check("R2 held", irq, 1);
        pulse_restart();
        check("R2 cleared", irq, 0);
        check("R3 reloaded", cnt_a, exp_base(24'd5));
    endtask

    task automatic t_mask();
        wr(3'd2, 24'h00);
        events(3'd1, 2);
        check("R4 empty mask", cnt_a, exp_base(24'd5));
        wr(3'd2, 24'h02);
        wr(3'd3, 24'h06);
        events(3'd1, 1);
        check("R4 both a", cnt_a, exp_base(24'd5) + 1);
        check("R4 both b", cnt_b, exp_base(24'd3) + 1);
        wr(3'd3, 24'h04);
    endtask

    task automatic t_big_trig();
        wr(3'd4, CMAX);
        pulse_restart();
        check("R3 trig at max", cnt_a, 0);
        wr(3'd4, 24'hFFFFFF);
        pulse_restart();
        check("R3 trig above", cnt_a, 0);
        wr(3'd4, 24'd5);
        wr(3'd0, 24'h000010);
        check("R6 negative clamp", elapsed_a, CMAX);
    endtask

    task automatic t_sat();
        wr(3'd0, 24'hFFFFFE);
        events(3'd1, 3);
        check("R5 saturate", cnt_a, 24'hFFFFFF);
        check("R2 irq at top", irq, 1);
    endtask

    task automatic t_prio();
        wr_en = 1; wr_addr = 3'd0; wr_data = 24'h123456;
        evt_valid = 1; evt_code = 3'd1;
        @(negedge clk);
        wr_en = 0; evt_valid = 0;
        check("R9 write over event", cnt_a, 24'h123456);
        wr_en = 1; wr_addr = 3'd1; wr_data = 24'h00ABCD; restart = 1;
        @(negedge clk);
        wr_en = 0; restart = 0;
        check("R9 write over restart", cnt_b, 24'h00ABCD);
        check("R3 restart other", cnt_a, exp_base(24'd5));
    endtask

    task automatic t_addr();
        wr(3'd6, 24'h777777);
        wr(3'd7, 24'h888888);
        check("R7 spare addr a", cnt_a, exp_base(24'd5));
        check("R7 spare addr b", cnt_b, 24'h00ABCD);
        events(3'd2, 1);
        check("R7 mask b kept", cnt_b, 24'h00ABCE);
    endtask

    task automatic t_aux();
        for (int i = 0; i < 3; i++) begin
            filt_evt = (i == 0) ? 2'b11 : 2'b01; @(negedge clk);
        end
        filt_evt = 0;
        check("R8 aux a", aux_a, 3);
        check("R8 aux b", aux_b, 1);
        svc_clr = 1; filt_evt = 2'b11; @(negedge clk);
        svc_clr = 0; filt_evt = 0;
        check("R8 clear wins", {aux_a, aux_b}, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_fire();
        t_mask();
        t_big_trig();
        t_sat();
        t_prio();
        t_addr();
        t_aux();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

endmodule